// File: doc/BRIEF.md
# NAND Status Register Readout Unit

This block sits on the device side of a NAND-style flash die. It decides what the die drives onto its 8-bit I/O bus during read cycles. Command bytes arrive with a latch strobe and set a read-output mode. There are three modes: array data, the normal status byte, or the extended status byte. The extended byte adds the error-detection result of a copy-back read.

A status mode stays selected for as long as no other command is latched. The host can therefore hold chip enable and read enable low and poll the byte. Ready/busy and write-protect changes appear on the bus at once, with no strobe toggled. The pass/fail bit belongs to the last completed operation and is captured when ready rises. The error flag and its validity bit are captured when a copy-back read completes. Both are cleared by commands outside the copy-back flow. The error flag reports one flipped bit in each 528-byte segment. A segment with several flipped bits is not reported as a separate case.

Top module: `nand_status_readout`

## Requirements
- R1: After reset the mode is array data, and pass/fail, the EDC error flag and EDC validity are all 0.
- R2: `io_oe` is 1 exactly when `ce_n` and `re_n` are both 0. While `io_oe` is 0, `io_out` is 8'h00.
- R3: Latching command 8'h70 selects normal status from the next clock edge. The byte is {bit7 = `wp_n`, bit6 = `rdy`, bits 5..1 = 0, bit0 = pass/fail (1 = fail)}.
- R4: Latching command 8'h7B selects EDC status from the next clock edge. The byte is {bit7 = `wp_n`, bit6 = `rdy`, bits 5..3 = 0, bit2 = EDC validity (1 = valid), bit1 = EDC error (1 = error), bit0 = pass/fail}.
- R5: The selected mode persists across any number of read cycles until a command is latched. Any latched command other than 8'h70 and 8'h7B, including 8'h00, selects array data, and `io_out` then equals `arr_data`.
- R6: While `ce_n` and `re_n` stay low, bits 7 and 6 of a status byte follow `wp_n` and `rdy` in the same cycle, with no clock edge and no strobe toggle.
- R7: Pass/fail takes the value of `op_fail` at a clock edge where `rdy` is 1 and was 0 at the previous edge. At every other edge it is held.
- R8: A `cb_rd_done` pulse sets EDC validity to 1 and loads the EDC error flag from `edc_err`. A latched command outside {8'h00, 8'h35, 8'h85, 8'h10, 8'h70, 8'h7B} clears both. If both events occur in the same cycle, `cb_rd_done` wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command latch strobe, one cycle per command byte |
| cmd_byte | input | 8 | Command byte latched when `cmd_we` is 1 |
| ce_n | input | 1 | Chip enable, active low |
| re_n | input | 1 | Read enable, active low |
| rdy | input | 1 | Internal ready (1) / busy (0) |
| op_fail | input | 1 | Fail result of the operation that is finishing |
| wp_n | input | 1 | Write-protect state, 1 = not protected |
| edc_err | input | 1 | Error detected by the copy-back read |
| cb_rd_done | input | 1 | One-cycle pulse when a copy-back read completes |
| arr_data | input | 8 | Array read data |
| io_out | output | 8 | Byte driven on the I/O bus |
| io_oe | output | 1 | Output enable for the I/O bus |

## Verification
Some properties are checked on every cycle. Whenever the bus is released, it must read as zero. One cycle after a status or EDC command, the upper bits must carry the live flags and the unused bits must be zero. One cycle after 8'h00, data mode must pass the array byte through. Pass/fail must not move while the die is busy, and validity must be set after a copy-back completion. Other behaviour shows only in the bench's scenarios. These are the capture of pass/fail on the ready edge and the mode held over many read cycles. They also cover the EDC flags that survive copy-back commands and are cleared by others, and same-cycle flag changes seen with both strobes held low.

// File: rtl/nand_status_readout.sv
module nand_status_readout #(
  parameter logic [7:0] CMD_READ   = 8'h00,
  parameter logic [7:0] CMD_STAT   = 8'h70,
  parameter logic [7:0] CMD_EDC    = 8'h7B,
  parameter logic [7:0] CMD_CB_RD  = 8'h35,
  parameter logic [7:0] CMD_CB_PG  = 8'h85,
  parameter logic [7:0] CMD_CONFIRM = 8'h10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       ce_n,
  input  logic       re_n,
  input  logic       rdy,
  input  logic       op_fail,
  input  logic       wp_n,
  input  logic       edc_err,
  input  logic       cb_rd_done,
  input  logic [7:0] arr_data,
  output logic [7:0] io_out,
  output logic       io_oe
);

  typedef enum logic [1:0] {M_DATA, M_STAT, M_EDC} mode_t;

  mode_t mode_q;
  logic  pf_q, rdy_q, err_q, vld_q;
  logic  keep_edc;
  logic [7:0] stat_b, edc_b;

  assign keep_edc = (cmd_byte == CMD_READ)  || (cmd_byte == CMD_STAT)  ||
                    (cmd_byte == CMD_EDC)   || (cmd_byte == CMD_CB_RD) ||
                    (cmd_byte == CMD_CB_PG) || (cmd_byte == CMD_CONFIRM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_DATA;
      pf_q   <= 1'b0;
      rdy_q  <= 1'b1;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      rdy_q <= rdy;
      if (rdy && !rdy_q)
        pf_q <= op_fail;
      if (cmd_we) begin
        if (cmd_byte == CMD_STAT)     mode_q <= M_STAT;
        else if (cmd_byte == CMD_EDC) mode_q <= M_EDC;
        else                          mode_q <= M_DATA;
      end
      if (cmd_we && !keep_edc) begin
        err_q <= 1'b0;
        vld_q <= 1'b0;
      end
      if (cb_rd_done) begin
        err_q <= edc_err;
        vld_q <= 1'b1;
      end
    end
  end

  assign stat_b = {wp_n, rdy, 5'b0, pf_q};
  assign edc_b  = {wp_n, rdy, 3'b0, vld_q, err_q, pf_q};
  assign io_oe  = ~ce_n & ~re_n;

  always_comb begin
    io_out = 8'h00;
    if (io_oe) begin
      case (mode_q)
        M_STAT:  io_out = stat_b;
        M_EDC:   io_out = edc_b;
        default: io_out = arr_data;
      endcase
    end
  end

endmodule

module nand_status_readout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_byte,
  input logic       rdy,
  input logic       wp_n,
  input logic       cb_rd_done,
  input logic [7:0] arr_data,
  input logic [7:0] io_out,
  input logic       io_oe,
  input logic       pf_q,
  input logic       vld_q
);

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_oe |-> io_out == 8'h00);

  p_status_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h70) ##1 io_oe |->
      (io_out[5:1] == 5'b0 && io_out[7] == wp_n && io_out[6] == rdy));

  p_edc_layout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h7B) ##1 io_oe |->
      (io_out[5:3] == 3'b0 && io_out[7] == wp_n && io_out[6] == rdy));

  p_data_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte == 8'h00) ##1 io_oe |-> io_out == arr_data);

  p_pf_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(pf_q));

  p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cb_rd_done |=> vld_q);

endmodule

bind nand_status_readout nand_status_readout_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .rdy(rdy), .wp_n(wp_n), .cb_rd_done(cb_rd_done), .arr_data(arr_data),
  .io_out(io_out), .io_oe(io_oe), .pf_q(pf_q), .vld_q(vld_q)
);

// File: tb/nand_status_readout_tb_top.sv
module nand_status_readout_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic ce_n = 1'b1, re_n = 1'b1;
  logic rdy = 1'b1, op_fail = 1'b0, wp_n = 1'b1, edc_err = 1'b0, cb_rd_done = 1'b0;
  logic [7:0] arr_data = 8'h00;
  logic [7:0] io_out;
  logic io_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nand_status_readout dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .ce_n(ce_n), .re_n(re_n), .rdy(rdy), .op_fail(op_fail), .wp_n(wp_n),
    .edc_err(edc_err), .cb_rd_done(cb_rd_done), .arr_data(arr_data),
    .io_out(io_out), .io_oe(io_oe)
  );

  // {cmd[7:0], rdy, wp_n, arr[7:0], expected[7:0]}
  localparam logic [25:0] VEC [0:7] = '{
    {8'h00, 1'b1, 1'b1, 8'hA5, 8'hA5},
    {8'h70, 1'b1, 1'b1, 8'h5A, 8'hC0},
    {8'h70, 1'b0, 1'b1, 8'h5A, 8'h80},
    {8'h70, 1'b1, 1'b0, 8'h5A, 8'h40},
    {8'h7B, 1'b1, 1'b1, 8'h33, 8'hC0},
    {8'h7B, 1'b0, 1'b0, 8'h33, 8'h00},
    {8'h00, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {8'hFF, 1'b1, 1'b1, 8'h96, 8'h96}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] c);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_byte = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    ce_n = 1'b0;
    re_n = 1'b0;
    #1;
    chk(req, io_out, exp);
    chk(req, {7'b0, io_oe}, 8'h01);
  endtask

  task automatic idle();
    ce_n = 1'b1;
    re_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R2 released bus", io_out, 8'h00);
    chk("R2 oe low", {7'b0, io_oe}, 8'h00);
    ce_n = 1'b0;
    #1;
    chk("R2 re high keeps oe low", {7'b0, io_oe}, 8'h00);
    arr_data = 8'h5C;
    rd("R1 reset data mode", 8'h5C);
    idle();
    latch(8'h7B);
    rd("R1 EDC flags clear after reset", 8'hC0);
    idle();

    for (int i = 0; i < 8; i++) begin
      latch(VEC[i][25:18]);
      rdy = VEC[i][17];
      wp_n = VEC[i][16];
      arr_data = VEC[i][15:8];
      rd("R3/R4/R5 vector", VEC[i][7:0]);
      idle();
    end

    // R5 persistence over many read cycles
    rdy = 1'b1; wp_n = 1'b1;
    latch(8'h70);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      arr_data = 8'h11 * k[7:0];
      rd("R5 status persists", 8'hC0);
      idle();
      #1;
      chk("R2 release between reads", io_out, 8'h00);
    end
    latch(8'h00);
    arr_data = 8'hE7;
    rd("R5 00h restores data", 8'hE7);
    idle();

    // R6 and R7: live flags and pass/fail capture
    latch(8'h70);
    @(negedge clk);
    rdy = 1'b0; op_fail = 1'b1;
    rd("R6 busy shows live", 8'h80);
    @(negedge clk);
    rdy = 1'b1;
    #1;
    chk("R6 ready shows live", io_out, 8'hC0);
    @(negedge clk);
    #1;
    chk("R7 fail captured on ready rise", io_out, 8'hC1);
    op_fail = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R7 held while ready", io_out, 8'hC1);
    wp_n = 1'b0;
    #1;
    chk("R6 write protect live", io_out, 8'h41);
    wp_n = 1'b1;
    rdy = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R7 held while busy", io_out, 8'h81);
    rdy = 1'b1;
    @(negedge clk);
    #1;
    chk("R7 pass captured", io_out, 8'hC0);
    idle();

    // R8 EDC flags
    @(negedge clk);
    edc_err = 1'b1; cb_rd_done = 1'b1;
    @(negedge clk);
    cb_rd_done = 1'b0; edc_err = 1'b0;
    latch(8'h7B);
    rd("R8 error and valid", 8'hC6);
    idle();
    latch(8'h35);
    latch(8'h7B);
    rd("R8 kept by copy-back command", 8'hC6);
    idle();
    latch(8'h70);
    rd("R3 status hides EDC bits", 8'hC0);
    idle();
    latch(8'h7B);
    rd("R8 kept by status command", 8'hC6);
    idle();
    latch(8'h80);
    latch(8'h7B);
    rd("R8 cleared by other command", 8'hC0);
    idle();
    @(negedge clk);
    cb_rd_done = 1'b1;
    @(negedge clk);
    cb_rd_done = 1'b0;
    rd("R8 valid without error", 8'hC4);
    idle();
    @(negedge clk);
    cmd_we = 1'b1; cmd_byte = 8'h60; cb_rd_done = 1'b1; edc_err = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; cb_rd_done = 1'b0; edc_err = 1'b0;
    latch(8'h7B);
    rd("R8 done wins over clear", 8'hC6);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule